// File: doc/BRIEF.md
# Downstream Bus Lock-Up Monitor

This block watches a set of downstream two-wire bus channels behind a bus switch. Each channel has a clock line and a data line. When either line of a channel stays low for too long, the block marks that channel as locked. It then acts according to a small set of configuration bits. It can command the switch to disconnect every channel, and it can ask an external waveform generator to clock the stuck channel free. It can also pull an active-low interrupt towards the host.

The host clears the lock flags by reading the status register. That read is signalled to the block by a one-cycle strobe. The same read also releases the interrupt. Optionally, the interrupt also releases on its own after a fixed delay. Both the lock threshold and the auto-release delay are given as parameters in system-clock cycles. A system integrator converts the tens-of-milliseconds and second-scale targets into cycle counts for the actual clock.

Top module: `lockup_monitor`

## Requirements
- R1: After reset, all lock flags are 0, the disconnect command is 0, all flush requests are 0 and `irq_no` is 1.
- R2: A channel's lock flag bit (bit index = channel number) is set after `LOCK_CYCLES` consecutive clock edges that see that channel's clock line or data line low. `LOCK_CYCLES-1` such edges do not set it.
- R3: The low-time count of a channel restarts only when both of its lines are sampled high. Low time that moves from one line to the other without both lines being high at the same time counts as one continuous interval.
- R4: Lock flags are sticky. They stay set after the lines recover, and are cleared by the status-read strobe. A detection in the same cycle as the read still sets its flag.
- R5: With the interrupt-enable bit at 0, a detection leaves `irq_no` at 1. With it at 1, `irq_no` goes to 0 in the same cycle the flag is set.
- R6: With the connected-only bit at 0, any detection sets the disconnect command. With it at 1, only a detection on a channel whose `sel_i` bit is 1 sets the command. A detection on a deselected channel still sets its flag and still raises the interrupt. The command clears on a status read.
- R7: With the flush-enable bit at 1, a detection sets the flush request bit of that channel. The bit clears one cycle after that channel's `flush_done_i` bit is 1. Done pulses of other channels leave it unchanged.
- R8: A status read releases `irq_no` to 1.
- R9: With the auto-release bit at 1, `irq_no` returns to 1 exactly `AUTOREL_CYCLES` cycles after it went low. With that bit at 0, it stays low until a status read.
- R10: One continuous low interval produces one detection. If the flag is cleared while the line is still held low, the flag stays clear until the lines have gone high and then low again for the full threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | NUM_CH | Sampled clock line level per channel |
| sda_i | input | NUM_CH | Sampled data line level per channel |
| sel_i | input | NUM_CH | Current channel-select mask of the switch |
| cfg_irq_en_i | input | 1 | Enable interrupt on a detection |
| cfg_flush_en_i | input | 1 | Enable flush request on a detection |
| cfg_autorel_en_i | input | 1 | Enable timed interrupt release |
| cfg_conn_only_i | input | 1 | Disconnect only on faults of selected channels |
| stat_rd_i | input | 1 | One-cycle strobe: host read the lock status |
| flush_done_i | input | NUM_CH | Flush completed on channel |
| lock_flags_o | output | NUM_CH | Sticky per-channel lock flags |
| disconnect_all_o | output | 1 | Command to open every channel switch |
| flush_req_o | output | NUM_CH | Per-channel flush-out request |
| irq_no | output | 1 | Interrupt, active low |

## Verification
The hardest condition to reach from the ports is a low interval that switches from one line to the other. The clock line is held low and then handed over to the data line in the same cycle that the clock line is released. The bench checks that the detection lands exactly on the combined count. A second hard case is a status read that clears a flag while its line is still held low. The bench holds that line low well past a second threshold to show that no new detection occurs. The bench covers both the detection threshold and the read-clear path with a sweep over every channel and both lines.

// File: rtl/lockup_pkg.sv
package lockup_pkg;
  typedef struct packed {
    logic irq_en;
    logic flush_en;
    logic autorel_en;
    logic conn_only;
  } lk_cfg_t;
endpackage

// File: rtl/lockup_chan_timer.sv
module lockup_chan_timer #(
  parameter int LOCK_CYCLES = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic hit_o
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          low;

  assign low   = !(scl_i && sda_i);
  // fires once per low interval; count saturates afterwards
  assign hit_o = low && (cnt_q == CW'(LOCK_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (!low)                      cnt_q <= '0;
    else if (cnt_q != CW'(LOCK_CYCLES)) cnt_q <= cnt_q + 1'b1;
  end

  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(LOCK_CYCLES));
  assert_single_hit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> !hit_o);
endmodule

// File: rtl/lockup_irq_ctrl.sv
module lockup_irq_ctrl
  import lockup_pkg::*;
#(
  parameter int AUTOREL_CYCLES = 20
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  lk_cfg_t cfg_i,
  input  logic    any_hit_i,
  input  logic    stat_rd_i,
  output logic    irq_no
);
  localparam int AW = $clog2(AUTOREL_CYCLES + 1);

  logic          pend_q;
  logic [AW-1:0] age_q;
  logic          set, rel;

  assign set = any_hit_i && cfg_i.irq_en;
  assign rel = stat_rd_i || (cfg_i.autorel_en && age_q == AW'(AUTOREL_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      age_q  <= '0;
    end else if (set) begin
      pend_q <= 1'b1;
      age_q  <= '0;
    end else if (pend_q && rel) begin
      pend_q <= 1'b0;
      age_q  <= '0;
    end else if (pend_q && cfg_i.autorel_en) begin
      age_q  <= age_q + 1'b1;
    end
  end

  assign irq_no = !pend_q;

  assert_irq_disabled_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!cfg_i.irq_en) && $past(irq_no)) |-> irq_no);
  assert_age_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    age_q < AW'(AUTOREL_CYCLES));
  assert_read_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(stat_rd_i) && !$past(set)) |-> irq_no);
endmodule

// File: rtl/lockup_monitor.sv
module lockup_monitor
  import lockup_pkg::*;
#(
  parameter int NUM_CH         = 8,
  parameter int LOCK_CYCLES    = 10,
  parameter int AUTOREL_CYCLES = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] scl_i,
  input  logic [NUM_CH-1:0] sda_i,
  input  logic [NUM_CH-1:0] sel_i,
  input  logic              cfg_irq_en_i,
  input  logic              cfg_flush_en_i,
  input  logic              cfg_autorel_en_i,
  input  logic              cfg_conn_only_i,
  input  logic              stat_rd_i,
  input  logic [NUM_CH-1:0] flush_done_i,
  output logic [NUM_CH-1:0] lock_flags_o,
  output logic              disconnect_all_o,
  output logic [NUM_CH-1:0] flush_req_o,
  output logic              irq_no
);
  lk_cfg_t           cfg;
  logic [NUM_CH-1:0] hits;
  logic [NUM_CH-1:0] disc_mask;
  logic [NUM_CH-1:0] flags_q, flush_q;
  logic              disc_q;

  assign cfg = '{irq_en: cfg_irq_en_i, flush_en: cfg_flush_en_i,
                 autorel_en: cfg_autorel_en_i, conn_only: cfg_conn_only_i};

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    lockup_chan_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_tmr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .scl_i (scl_i[i]),
      .sda_i (sda_i[i]),
      .hit_o (hits[i])
    );

    assert_flag_needs_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(scl_i[i] && sda_i[i]) |-> !(lock_flags_o[i] && !$past(lock_flags_o[i])));
    assert_flush_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(flush_done_i[i] && !hits[i]) |-> !flush_req_o[i]);
  end

  assign disc_mask = cfg.conn_only ? sel_i : {NUM_CH{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      flush_q <= '0;
      disc_q  <= 1'b0;
    end else begin
      flags_q <= (stat_rd_i ? '0 : flags_q) | hits;
      flush_q <= (flush_q & ~flush_done_i) | (hits & {NUM_CH{cfg.flush_en}});
      disc_q  <= (disc_q && !stat_rd_i) || |(hits & disc_mask);
    end
  end

  lockup_irq_ctrl #(.AUTOREL_CYCLES(AUTOREL_CYCLES)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cfg_i    (cfg),
    .any_hit_i(|hits),
    .stat_rd_i(stat_rd_i),
    .irq_no   (irq_no)
  );

  assign lock_flags_o     = flags_q;
  assign flush_req_o      = flush_q;
  assign disconnect_all_o = disc_q;

  assert_read_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(stat_rd_i) |-> ((lock_flags_o & ~$past(hits)) == '0));
  assert_no_disc_unselected_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cfg_conn_only_i && sel_i == '0) |-> !$rose(disconnect_all_o));
endmodule

// File: tb/lockup_monitor_tb.sv
module lockup_monitor_tb;
  localparam int N  = 8;
  localparam int L  = 10;
  localparam int AR = 20;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] scl = '1, sda = '1, sel = '0, fdone = '0;
  logic         c_irq = 0, c_flush = 0, c_auto = 0, c_conn = 0, rd = 0;
  logic [N-1:0] flags, freq;
  logic         disc, irq_n;
  int           checks = 0, errors = 0, cyc_cnt = 0;

  always #4 clk = ~clk;

  lockup_monitor #(.NUM_CH(N), .LOCK_CYCLES(L), .AUTOREL_CYCLES(AR)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda), .sel_i(sel),
    .cfg_irq_en_i(c_irq), .cfg_flush_en_i(c_flush), .cfg_autorel_en_i(c_auto),
    .cfg_conn_only_i(c_conn), .stat_rd_i(rd), .flush_done_i(fdone),
    .lock_flags_o(flags), .disconnect_all_o(disc), .flush_req_o(freq), .irq_no(irq_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_stat();
    rd = 1'b1; cyc(1); rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 100000) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 flags", flags, 0);
    chk("R1 disc", disc, 0);
    chk("R1 flush", freq, 0);
    chk("R1 irq", irq_n, 1);

    // sweep every channel and both lines, all options off
    for (int ch = 0; ch < N; ch++) begin
      for (int ln = 0; ln < 2; ln++) begin
        if (ln == 0) scl[ch] = 1'b0; else sda[ch] = 1'b0;
        cyc(L - 1);
        chk("R2 below threshold", flags, 0);
        cyc(1);
        chk("R2 at threshold", flags, 32'(1) << ch);
        chk("R6 any fault disconnects", disc, 1);
        chk("R5 irq disabled", irq_n, 1);
        chk("R7 flush disabled", freq, 0);
        scl[ch] = 1'b1; sda[ch] = 1'b1;
        cyc(3);
        chk("R4 sticky", flags, 32'(1) << ch);
        read_stat();
        chk("R4 read clears", flags, 0);
        chk("R6 read clears disc", disc, 0);
      end
    end

    // R3: both high for one cycle restarts the count
    scl[3] = 0; cyc(L - 1); scl[3] = 1; cyc(1); scl[3] = 0; cyc(L - 1);
    chk("R3 restart after high", flags, 0);
    cyc(1);
    chk("R3 full count after restart", flags, 32'h08);
    scl[3] = 1; cyc(1); read_stat();
    // R3: low time handed from clock line to data line counts continuously
    scl[5] = 0; cyc(4); scl[5] = 1; sda[5] = 0; cyc(L - 5);
    chk("R3 handover below", flags, 0);
    cyc(1);
    chk("R3 handover continuous", flags, 32'h20);
    // R10: read while still low, no new detection
    read_stat();
    cyc(L + 2);
    chk("R10 one detection per interval", flags, 0);
    sda[5] = 1; cyc(1);

    // R4: detection in the same cycle as a read keeps its flag
    sda[0] = 0; cyc(L - 1); rd = 1; cyc(1); rd = 0;
    chk("R4 set wins over read", flags, 32'h01);
    sda[0] = 1; cyc(1); read_stat();

    // R5, R8, R9: interrupt without auto-release
    c_irq = 1;
    scl[5] = 0; cyc(L);
    chk("R5 irq asserted", irq_n, 0);
    scl[5] = 1;
    cyc(AR + 10);
    chk("R9 no auto-release when off", irq_n, 0);
    read_stat();
    chk("R8 read releases irq", irq_n, 1);

    // R9: auto-release
    c_auto = 1;
    sda[2] = 0; cyc(L);
    chk("R9 irq asserted", irq_n, 0);
    sda[2] = 1;
    cyc(AR - 1);
    chk("R9 still held", irq_n, 0);
    cyc(1);
    chk("R9 released after delay", irq_n, 1);
    chk("R4 flags kept after auto-release", flags, 32'h04);
    read_stat();
    c_auto = 0;

    // R6: connected-only policy
    c_conn = 1; sel = 8'h04;
    scl[6] = 0; cyc(L);
    chk("R6 unselected no disconnect", disc, 0);
    chk("R6 unselected flag", flags, 32'h40);
    chk("R6 unselected irq", irq_n, 0);
    scl[6] = 1; cyc(1); read_stat();
    scl[2] = 0; cyc(L);
    chk("R6 selected disconnects", disc, 1);
    scl[2] = 1; cyc(1); read_stat();
    c_conn = 0; sel = '0;

    // R7: flush request and per-channel completion
    c_flush = 1;
    sda[1] = 0; sda[4] = 0; cyc(L);
    chk("R7 flush requested", freq, 32'h12);
    sda[1] = 1; sda[4] = 1;
    cyc(5);
    chk("R7 flush held", freq, 32'h12);
    fdone = 8'h01; cyc(1); fdone = '0;
    chk("R7 other done ignored", freq, 32'h12);
    fdone = 8'h02; cyc(1); fdone = '0;
    chk("R7 done clears channel", freq, 32'h10);
    fdone = 8'h10; cyc(1); fdone = '0;
    chk("R7 all done", freq, 0);
    read_stat();

    finish_run();
  end
endmodule